// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Controller

This block is the control sequencer of a small accumulator machine. It moves each instruction through register-level micro-steps. In the fetch cycle the program counter goes to the memory address register, a read is issued, and the returned word passes through the memory buffer register into the instruction register. An optional indirect cycle fetches the real operand address. The execute cycle then runs a load, an add into the accumulator, a store or a jump. The last step is the interrupt check, which can save the program counter on a downward-growing stack and redirect control to a handler address.

Every memory access uses one single-port memory. A read strobe or a write strobe is held, with the address and the write data held steady, until the memory answers with a ready pulse, so any memory latency works. Interrupts are sampled only once per instruction, after its execute step. Taking an interrupt masks further interrupts until the program runs the enable instruction again.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the PC, accumulator and interrupt enable read zero, the stack pointer reads all ones, and neither memory strobe is asserted.
- R2: Fetch reads the word at the address held in the PC. Instruction encoding: opcode in bits [15:12], indirect flag in bit 11, address field in bits [10:0]. Opcodes: 0 no-op, 1 load, 2 add, 3 store, 4 jump, 5 interrupt enable.
- R3: Once a read or write strobe is raised, it stays high with a stable address until mem_rdy is seen. The two strobes are never high together.
- R4: A direct load copies the addressed word into the accumulator. A direct add sums the addressed word into the accumulator. A direct store writes the accumulator to the addressed location. A direct jump loads the PC with the address field.
- R5: With the indirect flag set, one extra read fetches the effective address from the location named by the address field, and the load, store or jump then uses that effective address.
- R6: After an instruction completes with irq high and interrupts enabled, the PC of the next instruction is written to the location addressed by the stack pointer. The stack pointer then drops by one, the PC takes irq_vec and interrupts become disabled.
- R7: While interrupts are disabled, irq is ignored: nothing is saved, the stack pointer is unchanged and execution continues in sequence. Opcode 5 enables interrupts.
- R8: Opcodes 6 to 15 change nothing but the PC, which moves to the next instruction, and cause no memory access beyond their own fetch.
- R9: The PC increases by exactly one when the instruction word of a fetch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory address (registered) |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_rdata | input | 16 | Memory read data, taken when mem_rdy is high |
| mem_rd | output | 1 | Read strobe, held until mem_rdy |
| mem_wr | output | 1 | Write strobe, held until mem_rdy |
| mem_rdy | input | 1 | Memory completes the current access |
| irq | input | 1 | Interrupt request level |
| irq_vec | input | 11 | Handler address |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| sp_o | output | 11 | Stack pointer |
| ie_o | output | 1 | Interrupt enable |

## Verification
A wrong sequencer state shows at the memory port on the next access. The wrong address shows on mem_addr, or a strobe is missing or extra, one cycle after the bad transition. A corrupted PC shows up as a fetch from an unexpected address, and the bench stalls waiting for the expected fetch. A bad accumulator or a bad effective address surfaces only when a later store writes memory or the final register values are compared, a few instructions later. A mistake in the interrupt path leaves the wrong word at the top of the stack and a wrong stack pointer, both visible as soon as the handler's first fetch appears.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [3:0] {
    S_FADDR, S_FRD, S_FIR, S_DEC, S_IRD, S_IMV, S_ORD,
    S_ALU, S_SPREP, S_SWR, S_CHK, S_ISAVE, S_IWR
  } state_t;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_ADD   = 4'd2;
  localparam logic [3:0] OP_STORE = 4'd3;
  localparam logic [3:0] OP_JMP   = 4'd4;
  localparam logic [3:0] OP_EI    = 4'd5;

  function automatic logic is_rd_state(state_t s);
    return (s == S_FRD) || (s == S_IRD) || (s == S_ORD);
  endfunction

  function automatic logic is_wr_state(state_t s);
    return (s == S_SWR) || (s == S_IWR);
  endfunction

  function automatic logic uses_operand(logic [3:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/icc_seq.sv
module icc_seq
  import icc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_rdy,
  input  logic       irq,
  input  logic       ie,
  input  logic [3:0] op,
  input  logic       ind,
  output state_t     st,
  output logic       mem_rd,
  output logic       mem_wr
);
  state_t nxt;

  always_comb begin
    nxt = st;
    case (st)
      S_FADDR: nxt = S_FRD;
      S_FRD:   nxt = mem_rdy ? S_FIR : S_FRD;
      S_FIR:   nxt = S_DEC;
      S_DEC: begin
        if (uses_operand(op)) begin
          if (ind)                  nxt = S_IRD;
          else if (op == OP_STORE)  nxt = S_SPREP;
          else                      nxt = S_ORD;
        end else if (op == OP_JMP && ind) begin
          nxt = S_IRD;
        end else begin
          nxt = S_CHK;
        end
      end
      S_IRD:   nxt = mem_rdy ? S_IMV : S_IRD;
      S_IMV: begin
        if (op == OP_JMP)         nxt = S_CHK;
        else if (op == OP_STORE)  nxt = S_SPREP;
        else                      nxt = S_ORD;
      end
      S_ORD:   nxt = mem_rdy ? S_ALU : S_ORD;
      S_ALU:   nxt = S_CHK;
      S_SPREP: nxt = S_SWR;
      S_SWR:   nxt = mem_rdy ? S_CHK : S_SWR;
      S_CHK:   nxt = (irq && ie) ? S_ISAVE : S_FADDR;
      S_ISAVE: nxt = S_IWR;
      S_IWR:   nxt = mem_rdy ? S_FADDR : S_IWR;
      default: nxt = S_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_FADDR;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      st     <= nxt;
      mem_rd <= is_rd_state(nxt);
      mem_wr <= is_wr_state(nxt);
    end
  end
endmodule

// File: rtl/icc_alu.sv
module icc_alu
  import icc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] y
);
  always_comb begin
    if (op == OP_ADD) y = acc + opnd;
    else              y = opnd;
  end
endmodule

// File: rtl/icc_regs.sv
module icc_regs
  import icc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  state_t        st,
  input  logic          mem_rdy,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] irq_vec,
  input  logic [DW-1:0] alu_y,
  input  logic [3:0]    op,
  input  logic          ind,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] sp,
  output logic          ie
);
  localparam logic [AW-1:0] SP_TOP = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      sp  <= SP_TOP;
      ie  <= 1'b0;
    end else begin
      case (st)
        S_FADDR: mar <= pc;
        S_FRD: if (mem_rdy) begin
          mbr <= mem_rdata;
          pc  <= pc + 1'b1;
        end
        S_FIR: ir <= mbr;
        S_DEC: begin
          mar <= ir[AW-1:0];
          if (op == OP_JMP && !ind) pc <= ir[AW-1:0];
          if (op == OP_EI)          ie <= 1'b1;
        end
        S_IRD: if (mem_rdy) mbr <= mem_rdata;
        S_IMV: begin
          mar <= mbr[AW-1:0];
          if (op == OP_JMP) pc <= mbr[AW-1:0];
        end
        S_ORD: if (mem_rdy) mbr <= mem_rdata;
        S_ALU:   acc <= alu_y;
        S_SPREP: mbr <= acc;
        S_ISAVE: begin
          mbr <= DW'(pc);
          mar <= sp;
        end
        S_IWR: if (mem_rdy) begin
          sp <= sp - 1'b1;
          pc <= irq_vec;
          ie <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = DW - 5
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_rdy,
  input  logic          irq,
  input  logic [AW-1:0] irq_vec,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] sp_o,
  output logic          ie_o
);
  state_t        st;
  logic [DW-1:0] ir, mbr, acc, alu_y;
  logic [AW-1:0] mar, pc, sp;
  logic          ie;
  logic [3:0]    op;
  logic          ind;

  assign op  = ir[DW-1 -: 4];
  assign ind = ir[DW-5];

  icc_seq u_seq (
    .clk(clk), .rst(rst), .mem_rdy(mem_rdy), .irq(irq), .ie(ie),
    .op(op), .ind(ind), .st(st), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  icc_alu #(.DW(DW)) u_alu (
    .op(op), .acc(acc), .opnd(mbr), .y(alu_y)
  );

  icc_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .st(st), .mem_rdy(mem_rdy),
    .mem_rdata(mem_rdata), .irq_vec(irq_vec), .alu_y(alu_y),
    .op(op), .ind(ind), .pc(pc), .mar(mar), .mbr(mbr), .ir(ir),
    .acc(acc), .sp(sp), .ie(ie)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign pc_o      = pc;
  assign acc_o     = acc;
  assign sp_o      = sp;
  assign ie_o      = ie;
endmodule

// File: rtl/icc_chk.sv
module icc_chk
  import icc_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_rdy,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] irq_vec,
  input logic          ie,
  input state_t        st
);
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

  a_r3_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr)));

  a_r3_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_FRD && mem_rd && mem_rdy) |=> (pc == AW'($past(pc) + 1'b1)));

  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    (st == S_IWR && mem_wr && mem_rdy) |=> (pc == $past(irq_vec) && !ie));

  a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    (st == S_FRD && mem_rd) |-> (mem_addr == pc));
endmodule

bind instr_cycle_ctrl icc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_rdy(mem_rdy), .mem_addr(mem_addr), .pc(pc_o),
  .irq_vec(irq_vec), .ie(ie_o), .st(st)
);

// File: tb/instr_cycle_ctrl_tb.sv
module instr_cycle_ctrl_tb_top;
  localparam int DW = 16;
  localparam int AW = DW - 5;
  localparam int MSZ = 1 << AW;
  localparam logic [AW-1:0] SPTOP = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rd, mem_wr;
  logic          mem_rdy = 1'b0;
  logic          irq = 1'b0;
  logic [AW-1:0] irq_vec = '0;
  logic [AW-1:0] pc_o, sp_o;
  logic [DW-1:0] acc_o;
  logic          ie_o;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] mem [MSZ];
  int            lat = 0;
  int            cnt = 0;
  logic          pl_we = 1'b0, pl_clr = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [DW-1:0] pl_data = '0;

  always #4 clk = ~clk;

  instr_cycle_ctrl dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdy(mem_rdy), .irq(irq), .irq_vec(irq_vec), .pc_o(pc_o),
    .acc_o(acc_o), .sp_o(sp_o), .ie_o(ie_o)
  );

  // Memory model: answers after lat wait cycles, all writes made here.
  always @(negedge clk) begin
    if (pl_clr) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= '0;
    end else if (pl_we) begin
      mem[pl_addr] <= pl_data;
    end
    if (mem_rd || mem_wr) begin
      if (cnt >= lat) begin
        mem_rdy <= 1'b1;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
      end else begin
        mem_rdy <= 1'b0;
        cnt <= cnt + 1;
      end
    end else begin
      mem_rdy <= 1'b0;
      cnt <= 0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pl_addr = a; pl_data = d; pl_we = 1'b1;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic start(input int l);
    rst = 1'b1; irq = 1'b0; lat = l;
    pl_clr = 1'b1;
    @(negedge clk);
    pl_clr = 1'b0;
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_fetch(input logic [AW-1:0] a, input string tag);
    int n = 0;
    while (!(mem_rd && mem_addr == a) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, 32'(mem_addr), 32'(a));
    chk(pc_o == a, tag, 32'(pc_o), 32'(a));
  endtask

  task automatic t_reset();
    start(0);
    @(negedge clk);
    chk(pc_o == '0 && acc_o == '0, "R1 pc/acc in reset", 32'(pc_o), 0);
    chk(sp_o == SPTOP, "R1 sp in reset", 32'(sp_o), 32'(SPTOP));
    chk(!ie_o && !mem_rd && !mem_wr, "R1 ie/strobes in reset",
        {29'd0, ie_o, mem_rd, mem_wr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pc_o == '0 && !mem_wr, "R1 after release", 32'(pc_o), 0);
  endtask

  task automatic t_direct();
    start(0);
    poke(11'h000, 16'h1040);
    poke(11'h001, 16'h2041);
    poke(11'h002, 16'h3042);
    poke(11'h003, 16'h4003);
    poke(11'h040, 16'd5);
    poke(11'h041, 16'd7);
    go();
    wait_fetch(11'h003, "R2 R9 direct program reaches halt");
    chk(acc_o == 16'd12, "R4 load+add", 32'(acc_o), 12);
    chk(mem[11'h042] == 16'd12, "R4 store", 32'(mem[11'h042]), 12);
    repeat (20) @(negedge clk);
    wait_fetch(11'h003, "R4 jump holds loop");
  endtask

  task automatic t_indirect();
    start(3);
    poke(11'h000, 16'h1850);
    poke(11'h001, 16'h3851);
    poke(11'h002, 16'h4852);
    poke(11'h010, 16'h4010);
    poke(11'h050, 16'h0060);
    poke(11'h060, 16'h1234);
    poke(11'h051, 16'h0061);
    poke(11'h052, 16'h0010);
    go();
    wait_fetch(11'h010, "R5 indirect jump target");
    chk(acc_o == 16'h1234, "R5 indirect load", 32'(acc_o), 32'h1234);
    chk(mem[11'h061] == 16'h1234, "R5 indirect store", 32'(mem[11'h061]), 32'h1234);
    chk(mem[11'h051] == 16'h0061, "R5 pointer untouched", 32'(mem[11'h051]), 32'h61);
  endtask

  task automatic t_illegal();
    start(1);
    poke(11'h000, 16'h1040);
    poke(11'h001, 16'hF840);
    poke(11'h002, 16'h4002);
    poke(11'h040, 16'd9);
    go();
    wait_fetch(11'h002, "R8 illegal falls through");
    chk(acc_o == 16'd9 && !ie_o, "R8 acc/ie unchanged", 32'(acc_o), 9);
    chk(sp_o == SPTOP && mem[11'h040] == 16'd9, "R8 sp/memory unchanged",
        32'(mem[11'h040]), 9);
  endtask

  task automatic t_irq_taken();
    start(2);
    poke(11'h000, 16'h5000);
    poke(11'h001, 16'h0000);
    poke(11'h002, 16'h4002);
    poke(11'h080, 16'h4080);
    irq_vec = 11'h080;
    irq = 1'b1;
    go();
    wait_fetch(11'h080, "R6 handler fetched");
    chk(mem[SPTOP] == 16'h0001, "R6 saved pc", 32'(mem[SPTOP]), 1);
    chk(sp_o == SPTOP - 1'b1, "R6 sp decremented", 32'(sp_o), 32'(SPTOP - 1'b1));
    chk(!ie_o, "R6 interrupts masked", 32'(ie_o), 0);
    repeat (60) @(negedge clk);
    chk(sp_o == SPTOP - 1'b1, "R7 no re-entry while masked", 32'(sp_o),
        32'(SPTOP - 1'b1));
    irq = 1'b0;
  endtask

  task automatic t_irq_masked();
    start(0);
    poke(11'h000, 16'h0000);
    poke(11'h001, 16'h4001);
    poke(SPTOP, 16'hDEAD);
    irq_vec = 11'h080;
    irq = 1'b1;
    go();
    wait_fetch(11'h001, "R7 sequential while masked");
    repeat (50) @(negedge clk);
    wait_fetch(11'h001, "R7 still looping");
    chk(sp_o == SPTOP && mem[SPTOP] == 16'hDEAD, "R7 nothing saved",
        32'(mem[SPTOP]), 32'hDEAD);
    irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_indirect();
    t_illegal();
    t_irq_taken();
    t_irq_masked();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule